// File: doc/BRIEF.md
# Multi-mode interval timer channel

This block is a single down-counting interval timer channel. A host loads a count and a mode in one strobe. From then on the channel counts enable ticks and drives one output. The output's shape depends on the selected mode:

- a level that rises once the count is reached;
- a one-tick rate pulse at every multiple of the count;
- a square wave whose high half is the longer one for odd counts;
- a single one-tick strobe.

Internally the channel keeps the ticks elapsed since the last load. Every output decision follows from that figure and the loaded count alone. A count of zero selects the full period of 2^COUNT_W ticks. A complete timer uses three instances. The first two are built with `GATE_RST = 1` and the third with `GATE_RST = 0`.

A gate input is sampled into a register each clock. That register resets to `GATE_RST`. Elapsed time advances only on a clock where the tick input is high, the sampled gate is high and no load is taking place. A next-event output flags the clock on which the output is about to change. Channel 0 can therefore use it as an interrupt request.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel behaves as mode 3 with an effective count of 2^COUNT_W and zero elapsed ticks, so `out` is high. The sampled gate level starts at `GATE_RST`.
- R2: In modes 0 and 1, `out` is low while elapsed ticks are below the count, then goes high and stays high.
- R3: In mode 2, `out` is high exactly when the elapsed ticks are a nonzero multiple of the count, and low otherwise.
- R4: In mode 3, `out` is high while (elapsed mod count) is below (count+1)/2, and low for the rest of each period.
- R5: In modes 4 and 5, `out` is high only while elapsed ticks equal the count. It is low before and after that point.
- R6: Mode codes 6 and 7 behave exactly like mode 0.
- R7: A loaded count of 0 is taken as 2^COUNT_W.
- R8: A load strobe takes a new count and mode and restarts elapsed ticks at zero, even in the middle of a run. A tick on the load clock is not counted.
- R9: Elapsed ticks advance only on a clock where `tick` is high and the gate level sampled on the previous clock is high. Otherwise `out` holds.
- R10: `next_evt` is high on exactly those clocks where the coming clock edge will change `out` through elapsed time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one elapsed tick per high clock |
| gate | input | 1 | Gate level, registered before use |
| load | input | 1 | Load strobe for count and mode |
| load_count | input | COUNT_W | Count to load, 0 means 2^COUNT_W |
| load_mode | input | 3 | Mode code 0..7 |
| out | output | 1 | Channel output waveform |
| next_evt | output | 1 | Output changes at the coming edge |

## Verification
The bench builds the channel with `COUNT_W = 8` and `GATE_RST = 0`, which matches a third channel. The 8-bit width brings the zero-count case and the reset period of 256 ticks within a few hundred cycles. It also shows the square-wave behaviour after a full run. The low reset gate lets the bench check that time stays frozen until the gate is first seen high. The small counts 1 to 5 in every mode cover:

- odd and even square-wave halves;
- the degenerate count of 1;
- the out-of-range mode codes.

Random runs mix ticks, gate drops and reloads in the middle of a run.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int COUNT_W  = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               gate,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_count,
  input  logic [2:0]         load_mode,
  output logic               out,
  output logic               next_evt
);
  localparam int EW = COUNT_W + 1;
  localparam logic [EW-1:0] FULL = EW'(1) << COUNT_W;

  logic [2:0]    mode_q;
  logic [EW-1:0] count_q;
  logic [EW-1:0] el, el_nx;
  logic          nz, nz_nx;
  logic          gate_q;
  logic          adv;
  logic          periodic;
  logic [EW:0]   half_w;

  assign adv      = tick && gate_q && !load;
  assign periodic = (mode_q == 3'd2) || (mode_q == 3'd3);
  assign half_w   = ({1'b0, count_q} + (EW+1)'(1)) >> 1;

  function automatic logic shape(input logic [EW-1:0] e, input logic n);
    case (mode_q)
      3'd2:       shape = n && (e == '0);
      3'd3:       shape = {1'b0, e} < half_w;
      3'd4, 3'd5: shape = (e == count_q);
      default:    shape = (e >= count_q);
    endcase
  endfunction

  always_comb begin
    el_nx = el;
    nz_nx = nz;
    if (periodic) begin
      el_nx = (el == count_q - EW'(1)) ? '0 : el + EW'(1);
      nz_nx = 1'b1;
    end else if (el <= count_q) begin
      el_nx = el + EW'(1);
    end
  end

  assign out      = shape(el, nz);
  assign next_evt = adv && (shape(el_nx, nz_nx) != out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd3;
      count_q <= FULL;
      el      <= '0;
      nz      <= 1'b0;
      gate_q  <= GATE_RST;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q  <= (load_mode > 3'd5) ? 3'd0 : load_mode;
        count_q <= (load_count == '0) ? FULL : {1'b0, load_count};
        el      <= '0;
        nz      <= 1'b0;
      end else if (adv) begin
        el <= el_nx;
        nz <= nz_nx;
      end
    end
  end

  a_r10_evt_changes: assert property (@(posedge clk) disable iff (!rst_n)
    next_evt |=> (out != $past(out)));
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && gate_q)) |=> $stable(out));
  a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q <= 3'd1 && out && !load) |=> out);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q >= 3'd4 && out && adv) |=> !out);
  a_r6_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q <= 3'd5));
endmodule

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, gate = 0, load = 0;
  logic [W-1:0] load_count = '0;
  logic [2:0] load_mode = '0;
  logic out, next_evt;

  int n_chk = 0, n_bad = 0;
  int d, cnt, md;
  bit gq;
  string tag;

  pit_channel #(.COUNT_W(W), .GATE_RST(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .load_count(load_count), .load_mode(load_mode),
    .out(out), .next_evt(next_evt));

  always #2 clk = ~clk;

  function automatic bit refout(int e, int c, int m);
    case (m)
      2:       return (e != 0) && (e % c == 0);
      3:       return (e % c) < (c + 1) / 2;
      4, 5:    return e == c;
      default: return e >= c;
    endcase
  endfunction

  function automatic string mtag(int m);
    case (m)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      4, 5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string t, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (elapsed %0d count %0d mode %0d)",
               t, act, exp, d, cnt, md);
    end
  endtask

  task automatic step(bit ld, int c, int m, bit tk, bit gt);
    bit adv;
    @(negedge clk);
    load = ld; load_count = W'(c); load_mode = 3'(m); tick = tk; gate = gt;
    #1;
    check(tag, out, refout(d, cnt, md));
    adv = tk && gq && !ld;
    check("R10", next_evt, adv && (refout(d + 1, cnt, md) != refout(d, cnt, md)));
    @(posedge clk);
    if (ld) begin
      d = 0; cnt = (c == 0) ? (1 << W) : c; md = (m > 5) ? 0 : m;
    end else if (adv) d++;
    gq = gt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    d = 0; cnt = 1 << W; md = 3; gq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, (i > 1));
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 1);
    for (int m = 0; m < 8; m++)
      for (int c = 1; c <= 5; c++) begin
        tag = mtag(m);
        step(1, c, m, 1, 1);
        for (int i = 0; i < 3 * c + 6; i++) step(0, 0, 0, 1, 1);
      end
    tag = "R7";
    step(1, 0, 3, 1, 1);
    for (int i = 0; i < 520; i++) step(0, 0, 0, 1, 1);
    step(1, 0, 0, 1, 1);
    for (int i = 0; i < 260; i++) step(0, 0, 0, 1, 1);
    tag = "R8";
    step(1, 5, 4, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1);
    step(1, 3, 2, 1, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1);
    tag = "R9";
    step(1, 4, 3, 1, 1);
    for (int i = 0; i < 40; i++) step(0, 0, 0, (i % 3) != 0, (i % 5) > 1);
    for (int r = 0; r < 60; r++) begin
      int m, c;
      m = int'($urandom_range(0, 7));
      c = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 12));
      tag = (c == 0) ? "R7" : mtag(m);
      step(1, c, m, 1, 1);
      for (int i = 0; i < 50; i++) begin
        if ($urandom_range(0, 40) == 0) begin
          tag = "R8";
          step(1, int'($urandom_range(1, 9)), int'($urandom_range(0, 7)), 1, 1);
        end else
          step(0, 0, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 5) != 0);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule